// File: doc/BRIEF.md
# Counting Bloom Filter with Memory-Held Counts

This block keeps a counting Bloom filter for a large set, such as a cache tag array. Each hashed index selects one counter, held in a single-port synchronous count memory. The hash is computed outside the block. The owner of the large set sends an increment when an element is inserted and a decrement when one is removed. Before searching the large set, it sends a probe. A probe that answers "absent" means the element is certainly not in the set, so the expensive search can be skipped. Any other answer means the set must still be searched.

Updates are read-modify-write sequences that pass through a single shared up/down counter. A separate one-bit-per-entry zero-flag array records which counts are zero. Probes read only this flag, so a probe takes one cycle and never touches the count memory. The command port accepts a command when `cmd_valid` and `cmd_ready` are both high. Ready drops while an update is in flight.

Top module: `cbf_sram_filter`

## Requirements
- R1: After reset every entry's count is zero, so a probe of any index reports absent. After reset `cmd_ready` is high and both error flags are low.
- R2: Opcode 2'b11 is a probe. It is accepted on a rising edge with `cmd_valid` and `cmd_ready` high. `rsp_valid` is high for exactly the following cycle, with `rsp_absent` = 1 if and only if the indexed count is zero.
- R3: Opcode 2'b01 (increment) adds one to the indexed count, so a probe of that index then reports not absent.
- R4: Opcode 2'b10 (decrement) subtracts one from the indexed count. After N increments, the index reports absent again only after the Nth decrement.
- R5: An accepted increment or decrement holds `cmd_ready` low for the two cycles after acceptance (adjust, then write back). Ready returns high in the third cycle.
- R6: An update changes only the indexed entry. Probes of other indices are unaffected.
- R7: An increment of a count already at 2^CNT_W-1 leaves the count unchanged and sets `err_sat`. The flag stays set until reset.
- R8: A decrement of a zero count leaves the count at zero and sets `err_underflow`. The flag stays set until reset.
- R9: Opcode 2'b00 is accepted as a no-operation. It produces no response, leaves `cmd_ready` high and changes no count.
- R10: A probe does not lower `cmd_ready`, so probes may be accepted on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 2 | 00 no-op, 01 increment, 10 decrement, 11 probe |
| cmd_idx | input | $clog2(ENTRIES) | Hashed entry index |
| rsp_valid | output | 1 | Probe result strobe |
| rsp_absent | output | 1 | 1 = indexed count is zero, element definitely absent |
| err_sat | output | 1 | Sticky: increment at maximum count was dropped |
| err_underflow | output | 1 | Sticky: decrement at zero was dropped |

## Verification
The bench uses a narrow 3-bit count so that saturation can be reached. It interleaves increments and decrements on one index and checks that "absent" appears only when the two balance, which separates real counting from a simple set/clear bit. Neighbouring indices are probed around each update to catch address mix-ups. Pushing one count to its maximum and past it shows whether the dropped increment was truly dropped: exactly the maximum number of decrements must return the entry to absent. A decrement at zero, followed by one increment and one decrement, shows the same for underflow. Back-to-back probes and no-ops check the handshake timing against updates.

// File: rtl/cbf_pkg.sv
// Shared definitions for the counting Bloom filter.
// Assumes a 2-bit opcode field on the command port.
package cbf_pkg;
    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_INC   = 2'b01,
        OP_DEC   = 2'b10,
        OP_PROBE = 2'b11
    } cbf_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ADJ  = 2'b01,
        ST_WB   = 2'b10
    } cbf_state_e;
endpackage

// File: rtl/cbf_count_mem.sv
// Single-port synchronous count memory with one-cycle read latency.
// Assumes the caller never reads and writes in the same cycle.
// Contents are not reset; the zero-flag array marks stale words.
module cbf_count_mem #(
    parameter int DEPTH = 1024,
    parameter int DW    = 15,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Registered read or write on the single port.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/cbf_zflag_array.sv
// One zero flag per entry, set to one on reset (all counts zero).
// Combinational read, single synchronous write port.
module cbf_zflag_array #(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wflag,
    input  logic [AW-1:0] raddr,
    output logic          rflag
);
    logic [DEPTH-1:0] flags;

    for (genvar g = 0; g < DEPTH; g++) begin : g_flag
        // Hold one entry's flag; reset marks the entry empty.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  flags[g] <= 1'b1;
            else if (we && (waddr == AW'(g)))            flags[g] <= wflag;
        end
    end

    assign rflag = flags[raddr];
endmodule

// File: rtl/cbf_updown.sv
// Shared saturating up/down counter step (purely combinational).
// An increment at the maximum or a decrement at zero returns the input unchanged.
module cbf_updown #(
    parameter int DW = 15
) (
    input  logic [DW-1:0] cnt_in,
    input  logic          up,
    output logic [DW-1:0] cnt_out,
    output logic          sat,
    output logic          unf
);
    localparam logic [DW-1:0] MAXV = '1;

    // Select the adjusted count and report a dropped step.
    always_comb begin
        sat     = up && (cnt_in == MAXV);
        unf     = !up && (cnt_in == '0);
        cnt_out = cnt_in;
        if (up && !sat)       cnt_out = cnt_in + DW'(1);
        else if (!up && !unf) cnt_out = cnt_in - DW'(1);
    end
endmodule

// File: rtl/cbf_sram_filter.sv
// Counting Bloom filter top: sequencer, count memory, zero flags and shared counter.
// Accepts one command when cmd_valid && cmd_ready. A probe answers in the next cycle.
// An update reads (accept edge), adjusts (+1 edge) and writes back (+2 edge).
module cbf_sram_filter
    import cbf_pkg::*;
#(
    parameter int ENTRIES = 1024,
    parameter int CNT_W   = 15,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_idx,
    output logic             rsp_valid,
    output logic             rsp_absent,
    output logic             err_sat,
    output logic             err_underflow
);
    cbf_state_e       state;
    logic [IDX_W-1:0] idx_q;
    logic             up_q;
    logic             zf_q;
    logic [CNT_W-1:0] new_q;
    logic             accept, acc_upd, acc_probe;
    logic [CNT_W-1:0] mem_rdata, cnt_base, cnt_next;
    logic             step_sat, step_unf, zf_rd;
    logic             mem_en, mem_we;
    logic [IDX_W-1:0] mem_addr;
    logic             flag_we;

    assign cmd_ready = (state == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign acc_upd   = accept && ((cmd_op == OP_INC) || (cmd_op == OP_DEC));
    assign acc_probe = accept && (cmd_op == OP_PROBE);

    assign mem_en   = acc_upd || (state == ST_WB);
    assign mem_we   = (state == ST_WB);
    assign mem_addr = (state == ST_WB) ? idx_q : cmd_idx;
    assign flag_we  = (state == ST_WB) && (zf_q != (new_q == '0));

    cbf_count_mem #(.DEPTH(ENTRIES), .DW(CNT_W)) u_mem (
        .clk(clk), .en(mem_en), .we(mem_we), .addr(mem_addr),
        .wdata(new_q), .rdata(mem_rdata)
    );

    cbf_zflag_array #(.DEPTH(ENTRIES)) u_zf (
        .clk(clk), .rst_n(rst_n), .we(flag_we), .waddr(idx_q),
        .wflag(new_q == '0), .raddr(cmd_idx), .rflag(zf_rd)
    );

    // A set zero flag overrides the (possibly stale) memory word.
    assign cnt_base = zf_q ? '0 : mem_rdata;

    cbf_updown #(.DW(CNT_W)) u_cnt (
        .cnt_in(cnt_base), .up(up_q), .cnt_out(cnt_next),
        .sat(step_sat), .unf(step_unf)
    );

    // Sequence updates through read, adjust and write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx_q <= '0;
            up_q  <= 1'b0;
            zf_q  <= 1'b1;
            new_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (acc_upd) begin
                    state <= ST_ADJ;
                    idx_q <= cmd_idx;
                    up_q  <= (cmd_op == OP_INC);
                    zf_q  <= zf_rd;
                end
                ST_ADJ: begin
                    new_q <= cnt_next;
                    state <= ST_WB;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Probe response register, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_absent <= 1'b0;
        end else begin
            rsp_valid <= acc_probe;
            if (acc_probe) rsp_absent <= zf_rd;
        end
    end

    // Sticky error flags from dropped counter steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_sat       <= 1'b0;
            err_underflow <= 1'b0;
        end else if (state == ST_ADJ) begin
            if (step_sat) err_sat       <= 1'b1;
            if (step_unf) err_underflow <= 1'b1;
        end
    end
endmodule

// File: rtl/cbf_sram_filter_chk.sv
// Protocol checker for cbf_sram_filter, attached by bind.
module cbf_sram_filter_chk #(
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [1:0]       cmd_op,
    input logic [IDX_W-1:0] cmd_idx,
    input logic             rsp_valid,
    input logic             err_sat,
    input logic             err_underflow
);
    // R2
    rsp_after_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'b11) |=> rsp_valid);
    // R2
    rsp_only_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cmd_valid && cmd_ready && cmd_op == 2'b11)) |=> !rsp_valid);
    // R5
    busy_after_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_op == 2'b01 || cmd_op == 2'b10)) |=> !cmd_ready);
    // R10
    probe_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'b11) |=> cmd_ready);
    // R7
    sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_sat |=> err_sat);
    // R8
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |=> err_underflow);
endmodule

bind cbf_sram_filter cbf_sram_filter_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .rsp_valid(rsp_valid),
    .err_sat(err_sat), .err_underflow(err_underflow)
);

// File: tb/cbf_sram_filter_tb.sv
// Directed bench: one task per scenario, narrow counts to reach saturation.
module cbf_sram_filter_tb;
    localparam int ENT = 16;
    localparam int CW  = 3;
    localparam int IW  = $clog2(ENT);
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [IW-1:0] cmd_idx = '0;
    logic cmd_ready, rsp_valid, rsp_absent, err_sat, err_underflow;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cbf_sram_filter #(.ENTRIES(ENT), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_idx(cmd_idx), .rsp_valid(rsp_valid),
        .rsp_absent(rsp_absent), .err_sat(err_sat), .err_underflow(err_underflow)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Issue one update and check the busy window (R5).
    task automatic update(input logic [1:0] op, input int idx);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = IW'(idx);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R5 busy1", int'(cmd_ready), 0);
        @(negedge clk);
        check("R5 busy2", int'(cmd_ready), 0);
        @(negedge clk);
        check("R5 ready", int'(cmd_ready), 1);
    endtask

    // Probe one index and compare the absent bit (R2).
    task automatic probe(input string req, input int idx, input int exp_abs);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b11; cmd_idx = IW'(idx);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R2 rsp_valid", int'(rsp_valid), 1);
        check(req, int'(rsp_absent), exp_abs);
        @(negedge clk);
        check("R2 strobe width", int'(rsp_valid), 0);
    endtask

    task automatic t_reset();
        check("R1 ready", int'(cmd_ready), 1);
        check("R1 err_sat", int'(err_sat), 0);
        check("R1 err_underflow", int'(err_underflow), 0);
        for (int i = 0; i < ENT; i++) probe("R1 empty", i, 1);
    endtask

    task automatic t_count();
        update(2'b01, 3);
        probe("R3 inc present", 3, 0);
        probe("R6 neighbour low", 2, 1);
        probe("R6 neighbour high", 4, 1);
        update(2'b01, 3);
        update(2'b10, 3);
        probe("R4 one left", 3, 0);
        update(2'b10, 3);
        probe("R4 back to zero", 3, 1);
        check("R4 no underflow", int'(err_underflow), 0);
    endtask

    task automatic t_nop();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b00; cmd_idx = IW'(7);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R9 ready", int'(cmd_ready), 1);
        check("R9 no rsp", int'(rsp_valid), 0);
        probe("R9 unchanged", 7, 1);
    endtask

    task automatic t_b2b();
        update(2'b01, 9);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b11; cmd_idx = IW'(9);
        @(negedge clk);
        check("R10 ready after probe", int'(cmd_ready), 1);
        check("R10 first", int'(rsp_absent), 0);
        cmd_idx = IW'(10);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R10 second valid", int'(rsp_valid), 1);
        check("R10 second", int'(rsp_absent), 1);
        update(2'b10, 9);
    endtask

    task automatic t_sat();
        for (int i = 0; i < MAXC; i++) update(2'b01, 5);
        check("R7 no sat yet", int'(err_sat), 0);
        update(2'b01, 5);
        check("R7 sat set", int'(err_sat), 1);
        for (int i = 0; i < MAXC - 1; i++) update(2'b10, 5);
        probe("R7 held max", 5, 0);
        update(2'b10, 5);
        probe("R7 exact max", 5, 1);
        check("R7 sticky", int'(err_sat), 1);
    endtask

    task automatic t_unf();
        update(2'b10, 12);
        check("R8 unf set", int'(err_underflow), 1);
        probe("R8 still zero", 12, 1);
        update(2'b01, 12);
        probe("R8 one", 12, 0);
        update(2'b10, 12);
        probe("R8 zero again", 12, 1);
        check("R8 sticky", int'(err_underflow), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_nop();
        t_b2b();
        t_sat();
        t_unf();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) check("watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule